// File: doc/BRIEF.md
# Raster Window Region Detector

This block watches the pixel and line counters of a display timing generator and raises a single flag, `in_win`, while the raster position lies inside one programmed rectangle. Downstream logic uses that flag to decide where an overlay effect applies. The rectangle is held as start and end values in counter space, not screen space. The counters run through the blanking interval before the visible area, so each programmed value is the screen coordinate plus the back-porch length plus a small correction for each edge.

Software writes the horizontal and vertical window words through a small write port. A write lands in a pending copy. The copy the comparators use takes the pending values only when a frame begins, so a window never changes part-way through a frame. The start value is inclusive and the end value is exclusive. An end value equal to or below the start value gives an empty window on that axis.

The block also has a combinational converter. It turns a screen rectangle and the two back-porch lengths into the two register words, ready to be written.

Top module: `rwin_detect_top`

## Requirements
- R1: After reset, the pending and active windows are all zero and `in_win` is 0, so the window is empty until software programs it.
- R2: On every clock edge where `pix_en` is 1, `in_win` takes the value (h_start <= hcnt < h_end) AND (v_start <= vcnt < v_end), using the active window.
- R3: The start value of each axis is inclusive and the end value is exclusive: a counter equal to the end value gives 0, and a counter equal to the start value gives 1 when the other axis is inside.
- R4: On a clock edge where `pix_en` is 0, `in_win` keeps its previous value.
- R5: If end <= start on either axis, `in_win` is 0 for every counter position.
- R6: A write changes only the pending window. The active window loads the pending window at a frame start, which is a clock edge with `pix_en` = 1, `hcnt` = 0 and `vcnt` = 0. The frame-start pixel is already compared against the newly loaded values. A write made in the frame-start cycle itself is not part of that load.
- R7: `wr_sel` = 0 writes the horizontal word and `wr_sel` = 1 writes the vertical word. In each word the start value is bits 10:0 and the end value is bits 26:16. Bits 31:27 and 15:11 are ignored.
- R8: The converter outputs, all modulo 2048: h_start = x0 + h_bp - 2, h_end = x1 + h_bp - 1, v_start = y0 + v_bp + 1, v_end = y1 + v_bp + 2. Each is packed into a word with the layout of R7 and zeros in the ignored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; counters are valid when 1 |
| hcnt | input | 11 | Horizontal (pixel) counter |
| vcnt | input | 11 | Vertical (line) counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the horizontal word, 1 selects the vertical word |
| wr_data | input | 32 | Write word: start in 10:0, end in 26:16 |
| in_win | output | 1 | Registered in-window flag |
| scr_x0 | input | 11 | Converter: screen left edge |
| scr_x1 | input | 11 | Converter: screen right edge (exclusive) |
| scr_y0 | input | 11 | Converter: screen top edge |
| scr_y1 | input | 11 | Converter: screen bottom edge (exclusive) |
| h_bp | input | 11 | Converter: horizontal back-porch length |
| v_bp | input | 11 | Converter: vertical back-porch length |
| cvt_hword | output | 32 | Converter: horizontal register word |
| cvt_vword | output | 32 | Converter: vertical register word |

## Verification
The detector is probed at the pixels just before, at, and just after each edge of a programmed rectangle. These probes separate an inclusive start from an exclusive end and catch off-by-one errors on each axis. Windows with equal start and end values show that a degenerate axis suppresses the flag everywhere.

Writes are placed before a frame start, during a frame start taken with the enable low, and as a rectangle anchored at the origin. These cases tell deferred loading apart from immediate loading. They also check that the frame-start pixel itself sees the new values. Words with their ignored bits set, and converter inputs that wrap below zero, test field extraction and modular arithmetic.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int CW        = 11;
  localparam int DW        = 32;
  localparam int START_LSB = 0;
  localparam int END_LSB   = 16;

  typedef logic [CW-1:0] coord_t;

  // counter-domain edge values from screen coordinates and back porch
  function automatic coord_t cvt_h_start(coord_t scr, coord_t bp);
    return coord_t'(scr + bp - coord_t'(2));
  endfunction

  function automatic coord_t cvt_h_end(coord_t scr, coord_t bp);
    return coord_t'(scr + bp - coord_t'(1));
  endfunction

  function automatic coord_t cvt_v_start(coord_t scr, coord_t bp);
    return coord_t'(scr + bp + coord_t'(1));
  endfunction

  function automatic coord_t cvt_v_end(coord_t scr, coord_t bp);
    return coord_t'(scr + bp + coord_t'(2));
  endfunction

  function automatic logic [DW-1:0] pack_word(coord_t lo, coord_t hi);
    logic [DW-1:0] w;
    w = '0;
    w[START_LSB +: CW] = lo;
    w[END_LSB +: CW]   = hi;
    return w;
  endfunction

  function automatic coord_t word_lo(logic [DW-1:0] w);
    return w[START_LSB +: CW];
  endfunction

  function automatic coord_t word_hi(logic [DW-1:0] w);
    return w[END_LSB +: CW];
  endfunction
endpackage

// File: rtl/rwin_xlate.sv
module rwin_xlate
  import rwin_pkg::*;
(
  input  logic [CW-1:0] scr_x0,
  input  logic [CW-1:0] scr_x1,
  input  logic [CW-1:0] scr_y0,
  input  logic [CW-1:0] scr_y1,
  input  logic [CW-1:0] h_bp,
  input  logic [CW-1:0] v_bp,
  output logic [DW-1:0] hword,
  output logic [DW-1:0] vword
);
  coord_t h_lo, h_hi, v_lo, v_hi;

  always_comb begin
    h_lo  = cvt_h_start(scr_x0, h_bp);
    h_hi  = cvt_h_end(scr_x1, h_bp);
    v_lo  = cvt_v_start(scr_y0, v_bp);
    v_hi  = cvt_v_end(scr_y1, v_bp);
    hword = pack_word(h_lo, h_hi);
    vword = pack_word(v_lo, v_hi);
  end
endmodule

// File: rtl/rwin_regs.sv
module rwin_regs
  import rwin_pkg::*;
#(
  parameter int NAX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          frame_start,
  output logic [CW-1:0] eff_lo [NAX],
  output logic [CW-1:0] eff_hi [NAX]
);
  logic [CW-1:0] pend_lo [NAX];
  logic [CW-1:0] pend_hi [NAX];
  logic [CW-1:0] act_lo  [NAX];
  logic [CW-1:0] act_hi  [NAX];

  logic unused_rsvd;
  assign unused_rsvd = ^{wr_data[DW-1:END_LSB+CW], wr_data[END_LSB-1:START_LSB+CW]};

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    logic sel_me;
    assign sel_me = wr_en && (int'(wr_sel) == a);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_lo[a] <= '0;
        pend_hi[a] <= '0;
      end else if (sel_me) begin
        pend_lo[a] <= word_lo(wr_data);
        pend_hi[a] <= word_hi(wr_data);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_lo[a] <= '0;
        act_hi[a] <= '0;
      end else if (frame_start) begin
        act_lo[a] <= pend_lo[a];
        act_hi[a] <= pend_hi[a];
      end
    end

    assign eff_lo[a] = frame_start ? pend_lo[a] : act_lo[a];
    assign eff_hi[a] = frame_start ? pend_hi[a] : act_hi[a];

    // R6: active copy moves only at a frame start
    a_r6_act_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(act_lo[a]) && $stable(act_hi[a])));
  end
endmodule

// File: rtl/rwin_axis_cmp.sv
module rwin_axis_cmp #(
  parameter int CW = 11
) (
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic          empty,
  output logic          hit
);
  always_comb begin
    empty = (hi <= lo);
    hit   = !empty && (pos >= lo) && (pos < hi);
  end
endmodule

// File: rtl/rwin_detect_top.sv
module rwin_detect_top
  import rwin_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [10:0]   hcnt,
  input  logic [10:0]   vcnt,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [31:0]   wr_data,
  output logic          in_win,
  input  logic [10:0]   scr_x0,
  input  logic [10:0]   scr_x1,
  input  logic [10:0]   scr_y0,
  input  logic [10:0]   scr_y1,
  input  logic [10:0]   h_bp,
  input  logic [10:0]   v_bp,
  output logic [31:0]   cvt_hword,
  output logic [31:0]   cvt_vword
);
  localparam int NAX = 2;

  logic          frame_start;
  logic [CW-1:0] eff_lo [NAX];
  logic [CW-1:0] eff_hi [NAX];
  logic [CW-1:0] pos    [NAX];
  logic          ax_hit [NAX];
  logic          ax_emp [NAX];
  logic          win_hit;

  assign frame_start = pix_en && (hcnt == '0) && (vcnt == '0);
  assign pos[0] = hcnt;
  assign pos[1] = vcnt;

  rwin_regs #(.NAX(NAX)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .frame_start(frame_start),
    .eff_lo(eff_lo), .eff_hi(eff_hi)
  );

  for (genvar a = 0; a < NAX; a++) begin : g_cmp
    rwin_axis_cmp #(.CW(CW)) cmp_i (
      .pos(pos[a]), .lo(eff_lo[a]), .hi(eff_hi[a]),
      .empty(ax_emp[a]), .hit(ax_hit[a])
    );
  end

  assign win_hit = ax_hit[0] && ax_hit[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      in_win <= 1'b0;
    else if (pix_en) in_win <= win_hit;
  end

  rwin_xlate xlate_i (
    .scr_x0(scr_x0), .scr_x1(scr_x1), .scr_y0(scr_y0), .scr_y1(scr_y1),
    .h_bp(h_bp), .v_bp(v_bp), .hword(cvt_hword), .vword(cvt_vword)
  );

  // R4: enable low holds the flag
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(in_win));

  // R3: end value exclusive on the horizontal axis
  a_r3_end_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && hcnt == eff_hi[0]) |=> !in_win);

  // R3: below start is outside
  a_r3_below_start: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && vcnt < eff_lo[1]) |=> !in_win);

  // R5: degenerate vertical axis suppresses the flag
  a_r5_empty_axis: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && eff_hi[1] <= eff_lo[1]) |=> !in_win);

  // R2: fully inside position raises the flag
  a_r2_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && hcnt >= eff_lo[0] && hcnt < eff_hi[0]
            && vcnt >= eff_lo[1] && vcnt < eff_hi[1]) |=> in_win);
endmodule

// File: tb/rwin_detect_top_tb_top.sv
module rwin_detect_top_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, pix_en, wr_en, wr_sel, in_win;
  logic [10:0] hcnt, vcnt, scr_x0, scr_x1, scr_y0, scr_y1, h_bp, v_bp;
  logic [31:0] wr_data, cvt_hword, cvt_vword;

  rwin_detect_top dut_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hcnt(hcnt), .vcnt(vcnt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .in_win(in_win),
    .scr_x0(scr_x0), .scr_x1(scr_x1), .scr_y0(scr_y0), .scr_y1(scr_y1),
    .h_bp(h_bp), .v_bp(v_bp), .cvt_hword(cvt_hword), .cvt_vword(cvt_vword)
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int m_pend[4];  // 0 h start, 1 h end, 2 v start, 3 v end
  int m_act[4];
  logic m_last = 1'b0;

  task automatic chk(input logic [31:0] act, exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int h, v, input logic en, input string tag);
    bit fs;
    int w[4];
    @(negedge clk);
    wr_en = 0; hcnt = 11'(h); vcnt = 11'(v); pix_en = en;
    fs = en && h == 0 && v == 0;
    for (int i = 0; i < 4; i++) w[i] = fs ? m_pend[i] : m_act[i];
    if (fs) for (int i = 0; i < 4; i++) m_act[i] = m_pend[i];
    if (en) m_last = (h >= w[0] && h < w[1] && v >= w[2] && v < w[3]);
    q.push_back('{m_last, tag});
  endtask

  task automatic wr(input logic sel, input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d; pix_en = 0;
    m_pend[sel ? 2 : 0] = int'(d[10:0]);
    m_pend[sel ? 3 : 1] = int'(d[26:16]);
    q.push_back('{m_last, tag});
  endtask

  function automatic logic [31:0] mk(input int lo, hi);
    return (32'(hi % 2048) << 16) | 32'(lo % 2048);
  endfunction

  // monitor: compare after each edge
  always @(posedge clk) begin
    item_t it;
    #1;
    if (!done && q.size() > 0) begin
      it = q.pop_front();
      chk({31'b0, in_win}, {31'b0, it.exp}, it.tag);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  task automatic cvt_check(input int x0, x1, y0, y1, hb, vb);
    @(negedge clk);
    scr_x0 = 11'(x0); scr_x1 = 11'(x1); scr_y0 = 11'(y0); scr_y1 = 11'(y1);
    h_bp = 11'(hb); v_bp = 11'(vb);
    #1;
    chk(cvt_hword, mk((x0 + hb - 2 + 2048) % 2048, (x1 + hb - 1 + 2048) % 2048), "R8 hword");
    chk(cvt_vword, mk((y0 + vb + 1) % 2048, (y1 + vb + 2) % 2048), "R8 vword");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_act[i] = 0; end
    rst_n = 0; pix_en = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    hcnt = '0; vcnt = '0;
    scr_x0 = '0; scr_x1 = '0; scr_y0 = '0; scr_y1 = '0; h_bp = '0; v_bp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk({31'b0, in_win}, 32'd0, "R1 reset flag");
    // R1: reset window empty everywhere
    step(0, 0, 1, "R1 frame start empty");
    step(0, 1, 1, "R1 empty");
    step(5, 5, 1, "R1 empty");
    // R7 with reserved bits set: h 10..20, v 5..8
    wr(0, 32'hF814_F80A, "R7 write h");
    wr(1, mk(5, 8), "R7 write v");
    step(12, 6, 1, "R6 pending not yet active");
    step(0, 0, 1, "R6 frame start load");
    step(9, 6, 1, "R3 before h start");
    step(10, 6, 1, "R3 h start inclusive");
    step(19, 7, 1, "R2 inside");
    step(20, 7, 1, "R3 h end exclusive");
    step(15, 4, 1, "R3 before v start");
    step(15, 5, 1, "R3 v start inclusive");
    step(15, 8, 1, "R3 v end exclusive");
    step(15, 6, 1, "R2 inside again");
    step(300, 300, 0, "R4 hold high");
    step(1, 1, 0, "R4 hold high");
    step(1, 1, 1, "R2 outside");
    step(15, 6, 0, "R4 hold low");
    // R6: frame start without enable does not load
    wr(0, mk(0, 4), "R6 write origin h");
    wr(1, mk(0, 3), "R6 write origin v");
    step(0, 0, 0, "R6 no enable no load");
    step(15, 6, 1, "R6 old window still");
    step(2, 2, 1, "R6 new not active");
    step(0, 0, 1, "R6 frame start pixel uses new");
    step(3, 2, 1, "R6 new inside");
    step(15, 6, 1, "R6 old region now out");
    // R5: degenerate axes
    wr(0, mk(30, 30), "R5 write equal");
    wr(1, mk(0, 100), "R5 write v");
    step(0, 0, 1, "R5 load");
    step(30, 10, 1, "R5 equal empty");
    step(29, 10, 1, "R5 equal empty");
    wr(0, mk(50, 40), "R5 write reversed");
    step(0, 0, 1, "R5 load reversed");
    step(45, 10, 1, "R5 reversed empty");
    step(50, 10, 1, "R5 reversed empty");
    // R8 converter
    cvt_check(100, 740, 20, 500, 48, 33);
    cvt_check(0, 2047, 2040, 7, 1, 10);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule